// File: doc/BRIEF.md
# Converter Serial Result Port

This block is the digital half of a data converter's single-cycle serial port. An external master clocks it. The port tracks whether the converter is still converting or is asleep holding a finished result. While its chip select is low it drives a serial line. Between frames that line reports conversion status. During a frame it carries a 32-bit result word. In the same frame it collects a configuration word that the master shifts in on its data input. The chip select, serial clock and data input are synchronized into the system clock `clk`. Their edges are detected there, so every serial action happens a few system cycles after the pin changes.

Results arrive on a valid/ready stream from a stand-in conversion source. `res_ready` is high only while a conversion is in progress and at least `CONV_CYCLES` system cycles have passed since that conversion began. A result is taken on the cycle where `res_valid` and `res_ready` are both high. A source that holds `res_valid` low stretches the conversion for as long as it likes. `res_data` is ignored in every other cycle. Its top bit is the sign, and the remaining bits are the result from the most significant bit down.

Each completed frame starts the next conversion by itself. A frame may be abandoned by raising chip select before it completes.

Top module: `adcif_serial_port`

## Requirements
- R1: `sdo_oe` is low while the synchronized chip select is high and high while it is low; the delay from `cs_n` is `SYNC_STAGES` cycles.
- R2: With chip select low and no frame in progress, `sdo` equals 1 while converting and 0 while asleep with a result held.
- R3: `busy` stays high from the start of a conversion until a result is accepted. `res_ready` is high only while `busy` is high, and no earlier than the `CONV_CYCLES`-th cycle of the conversion. With `res_valid` held high, `busy` is high for exactly `CONV_CYCLES` cycles.
- R4: An accepted result puts the block to sleep on the next cycle with `busy` low, whatever chip select is doing. While `res_valid` is low the conversion is held open. Data offered while `res_ready` is low is not taken.
- R5: A frame begins only on a rising serial clock edge seen while chip select is low and the block is asleep. Rising edges while chip select is high change nothing.
- R6: A frame carries 32 bits, most significant first, each changing on a falling edge and stable at the next rising edge. Bit 31 is the status flag (0), bit 30 is a fixed 0, bit 29 is the sign (`res_data[29]`), and bits 28..0 are `res_data[28:0]` of the held result.
- R7: On the 32nd falling serial clock edge of a frame, a new conversion starts: `busy` and `sdo` both go high.
- R8: The first 13 bits shifted in on `sdi` (sampled on rising edges) form the configuration word. In arrival order these are: preamble 1, preamble 0, enable, `cfg_sgl`, `cfg_odd`, `cfg_addr` (3 bits, MSB first), `cfg_osr` (4 bits, MSB first) and `cfg_twox`. The fields are updated when the frame completes, and only there.
- R9: A configuration word whose preamble is not 1,0 or whose enable bit is 0 leaves every field unchanged.
- R10: If chip select rises before the 32nd falling edge, the frame is dropped. `sdo_oe` goes low, the block stays asleep, the held result is read again in full by the next frame, and the configuration is not updated.
- R11: Serial clock edges during a conversion have no effect: `busy` and `sdo` stay high and the result later read is the one accepted.
- R12: After reset the block is converting (`busy` high) and all configuration fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial configuration input |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready |
| res_data | input | FRAME_BITS-2 | Result word, sign in the top bit |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for `sdo` (tristate control) |
| busy | output | 1 | High while a conversion is in progress |
| cfg_sgl | output | 1 | Single-ended / differential select |
| cfg_odd | output | 1 | Odd / polarity select |
| cfg_addr | output | 3 | Channel address |
| cfg_osr | output | 4 | Oversampling ratio code |
| cfg_twox | output | 1 | Speed-doubling select |

## Verification
Several properties are checked on every cycle: the output enable tracks the delayed chip select, ready is gated by busy and by the minimum conversion length, every handshake is followed by sleep, busy holds while no result is accepted, a high status line accompanies busy, and the configuration stays frozen through a conversion. Other behaviour is visible only in the bench scenarios: bit order and content of the frame, which configuration words are accepted, and that ignored clock edges and aborted frames leave the held result intact. Those scenarios sweep eight result and configuration patterns, then cover malformed words, edges with chip select high, a mid-frame abort and a stalled result stream.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  localparam int ADDR_W = 3;
  localparam int OSR_W  = 4;
  // preamble(2) + enable + sgl + odd + addr + osr + twox
  localparam int CFG_W  = 2 + 3 + ADDR_W + OSR_W + 1;
  localparam int FLD_W  = CFG_W - 3;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_FRAME = 2'd2
  } port_state_e;

  typedef struct packed {
    logic              sgl;
    logic              odd;
    logic [ADDR_W-1:0] addr;
    logic [OSR_W-1:0]  osr;
    logic              twox;
  } cfg_t;
endpackage

// File: rtl/adcif_sync.sv
module adcif_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl  = stg_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/adcif_conv_timer.sv
module adcif_conv_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOADV = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= LOADV;
    else if (start)         cnt_q <= LOADV;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/adcif_cfg_capture.sv
module adcif_cfg_capture
  import adcif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic shift_en,
  input  logic sdi,
  input  logic commit,
  output cfg_t cfg
);
  localparam int NW = $clog2(CFG_W + 1);
  localparam logic [NW-1:0] FULL = NW'(CFG_W);

  logic [CFG_W-1:0] sh_q;
  logic [NW-1:0]    n_q;
  cfg_t             cfg_q;
  logic             word_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      n_q  <= '0;
    end else if (load) begin
      sh_q <= {{(CFG_W-1){1'b0}}, sdi};
      n_q  <= NW'(1);
    end else if (shift_en && n_q != FULL) begin
      sh_q <= {sh_q[CFG_W-2:0], sdi};
      n_q  <= n_q + 1'b1;
    end
  end

  assign word_ok = (sh_q[CFG_W-1 -: 2] == 2'b10) && sh_q[CFG_W-3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cfg_q <= '0;
    else if (commit && word_ok)  cfg_q <= cfg_t'(sh_q[FLD_W-1:0]);
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/adcif_serial_port.sv
module adcif_serial_port
  import adcif_pkg::*;
#(
  parameter int  FRAME_BITS  = 32,
  parameter int  CONV_CYCLES = 1000,
  parameter int  SYNC_STAGES = 2,
  localparam int DATA_W      = FRAME_BITS - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              cfg_sgl,
  output logic              cfg_odd,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [OSR_W-1:0]  cfg_osr,
  output logic              cfg_twox
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_BITS - 1);

  // synchronized pins: bit 0 cs_n, bit 1 sck, bit 2 sdi
  logic [2:0] pin_lvl, pin_rise, pin_fall;

  adcif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({sdi, sck, cs_n}),
    .lvl   (pin_lvl),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  logic cs_act, sck_rise, sck_fall, sdi_s;
  assign cs_act   = ~pin_lvl[0];
  assign sck_rise = pin_rise[1];
  assign sck_fall = pin_fall[1];
  assign sdi_s    = pin_lvl[2];

  port_state_e       state_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [DATA_W-1:0] held_q;
  logic [CNT_W-1:0]  fcnt_q;

  logic tmr_done, accept, frame_start, frame_abort, frame_end, in_frame;

  assign in_frame    = (state_q == ST_FRAME);
  assign res_ready   = (state_q == ST_CONV) && tmr_done;
  assign accept      = res_valid && res_ready;
  assign frame_start = (state_q == ST_SLEEP) && cs_act && sck_rise;
  assign frame_abort = in_frame && !cs_act;
  assign frame_end   = in_frame && cs_act && sck_fall && (fcnt_q == LAST_FALL);

  adcif_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (frame_end),
    .done  (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CONV;
      sh_q    <= '0;
      held_q  <= '0;
      fcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_CONV: begin
          if (accept) begin
            held_q  <= res_data;
            state_q <= ST_SLEEP;
          end
        end
        ST_SLEEP: begin
          if (frame_start) begin
            sh_q    <= {2'b00, held_q};
            fcnt_q  <= '0;
            state_q <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (frame_abort) begin
            state_q <= ST_SLEEP;
          end else if (sck_fall) begin
            if (fcnt_q == LAST_FALL) begin
              state_q <= ST_CONV;
            end else begin
              sh_q   <= {sh_q[FRAME_BITS-2:0], 1'b0};
              fcnt_q <= fcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_CONV;
      endcase
    end
  end

  cfg_t cfg;

  adcif_cfg_capture u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_start),
    .shift_en (in_frame && cs_act && sck_rise),
    .sdi      (sdi_s),
    .commit   (frame_end),
    .cfg      (cfg)
  );

  assign busy     = (state_q == ST_CONV);
  assign sdo      = in_frame ? sh_q[FRAME_BITS-1] : busy;
  assign sdo_oe   = cs_act;
  assign cfg_sgl  = cfg.sgl;
  assign cfg_odd  = cfg.odd;
  assign cfg_addr = cfg.addr;
  assign cfg_osr  = cfg.osr;
  assign cfg_twox = cfg.twox;
endmodule

// File: rtl/adcif_serial_port_chk.sv
module adcif_serial_port_chk #(
  parameter int CONV_CYCLES = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int FW          = adcif_pkg::FLD_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          res_valid,
  input logic          res_ready,
  input logic          busy,
  input logic          sdo,
  input logic          sdo_oe,
  input logic [FW-1:0] cfg_bus
);
  logic [SYNC_STAGES-1:0] cs_dly;
  logic [31:0]            run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_dly <= '1;
    end else begin
      cs_dly[0] <= cs_n;
      for (int i = 1; i < SYNC_STAGES; i++) cs_dly[i] <= cs_dly[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              run_q <= '0;
    else if (!busy)                          run_q <= '0;
    else if (run_q < 32'(CONV_CYCLES))       run_q <= run_q + 1'b1;
  end

  AST_OE_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe == !cs_dly[SYNC_STAGES-1]); // R1

  AST_BUSY_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> sdo); // R2

  AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> busy); // R3

  AST_MIN_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> (run_q >= 32'(CONV_CYCLES - 1))); // R3

  AST_ACCEPT_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !busy); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(res_valid && res_ready)) |=> busy); // R4

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_bus)); // R8
endmodule

bind adcif_serial_port adcif_serial_port_chk #(
  .CONV_CYCLES (CONV_CYCLES),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .busy      (busy),
  .sdo       (sdo),
  .sdo_oe    (sdo_oe),
  .cfg_bus   ({cfg_sgl, cfg_odd, cfg_addr, cfg_osr, cfg_twox})
);

// File: tb/sim_adcif_serial_port.sv
module sim_adcif_serial_port;
  localparam int FB   = 32;
  localparam int DW   = FB - 2;
  localparam int CC   = 20;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, sdi, res_valid, res_ready;
  logic [DW-1:0] res_data;
  logic sdo, sdo_oe, busy, cfg_sgl, cfg_odd, cfg_twox;
  logic [2:0] cfg_addr;
  logic [3:0] cfg_osr;

  always #5 clk = ~clk;

  adcif_serial_port #(.FRAME_BITS(FB), .CONV_CYCLES(CC), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy),
    .cfg_sgl(cfg_sgl), .cfg_odd(cfg_odd), .cfg_addr(cfg_addr),
    .cfg_osr(cfg_osr), .cfg_twox(cfg_twox)
  );

  int checks = 0;
  int errors = 0;
  int run_len = 0;
  int last_len = 0;

  always @(posedge clk) begin
    if (rst_n === 1'b1 && busy === 1'b1) run_len <= run_len + 1;
    else if (run_len != 0) begin
      last_len <= run_len;
      run_len  <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_sleep();
    for (int i = 0; i < 2000 && busy; i++) tick(1);
    tick(2);
  endtask

  task automatic pulse_sck(input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1; tick(HALF);
      sck = 1'b0; tick(HALF);
    end
  endtask

  task automatic do_frame(input logic [12:0] cfgw, input int nclk,
                          output logic [FB-1:0] got);
    got = '0;
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 13) ? cfgw[12-i] : 1'b0;
      tick(3);
      got[FB-1-i] = sdo;
      sck = 1'b1; tick(HALF);
      sck = 1'b0; tick(HALF);
    end
    sdi = 1'b0;
  endtask

  function automatic logic [DW-1:0] mkdata(input int k);
    logic [31:0] kk;
    kk = k;
    case (k)
      0: mkdata = '1;
      1: mkdata = DW'(32'h2000_0000);
      2: mkdata = '0;
      default: mkdata = DW'((kk * 32'h1357_9BDF) ^ (32'h0F0F_0F0F >> kk[3:0]));
    endcase
  endfunction

  function automatic logic [12:0] mkcfg(input int k);
    logic [31:0] kk;
    logic [3:0]  osr;
    kk  = k;
    osr = 4'(15 - 2 * k);
    mkcfg = {2'b10, 1'b1, kk[0], kk[1], kk[2:0], osr, kk[0] ^ kk[2]};
  endfunction

  function automatic logic [9:0] cfg_now();
    cfg_now = {cfg_sgl, cfg_odd, cfg_addr, cfg_osr, cfg_twox};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    logic [FB-1:0] got;
    logic [9:0]    exp_cfg;
    logic [12:0]   cw;

    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    res_valid = 1'b1; res_data = mkdata(7);
    held = mkdata(7); exp_cfg = '0;
    tick(5);
    chk(busy === 1'b1, "R12", "busy in reset", 32'(busy), 32'd1);
    chk(cfg_now() === 10'd0, "R12", "cfg in reset", 32'(cfg_now()), 32'd0);
    chk(sdo_oe === 1'b0, "R1", "oe with cs high", 32'(sdo_oe), 32'd0);
    rst_n = 1'b1;
    tick(1);
    cs_n = 1'b0;
    tick(4);
    chk(sdo_oe === 1'b1, "R1", "oe with cs low", 32'(sdo_oe), 32'd1);
    chk(sdo === 1'b1 && busy === 1'b1, "R2", "flag while converting", 32'(sdo), 32'd1);
    wait_sleep();
    chk(busy === 1'b0, "R4", "asleep after result", 32'(busy), 32'd0);
    chk(sdo === 1'b0, "R2", "flag while asleep", 32'(sdo), 32'd0);
    chk(res_ready === 1'b0, "R4", "ready low in sleep", 32'(res_ready), 32'd0);

    // sweep of result and configuration patterns (R6 R7 R8 R3)
    for (int k = 0; k < 8; k++) begin
      res_data = mkdata(k);
      cw = mkcfg(k);
      do_frame(cw, FB, got);
      chk(got === {2'b00, held}, "R6", "frame content", got, {2'b00, held});
      tick(HALF);
      chk(busy === 1'b1 && sdo === 1'b1, "R7", "new conversion at frame end",
          32'({busy, sdo}), 32'd3);
      wait_sleep();
      chk(last_len == CC, "R3", "conversion length", 32'(last_len), 32'(CC));
      exp_cfg = cw[9:0];
      chk(cfg_now() === exp_cfg, "R8", "cfg fields", 32'(cfg_now()), 32'(exp_cfg));
      held = mkdata(k);
    end

    // malformed configuration words (R9)
    res_data = mkdata(11);
    do_frame({2'b11, 1'b1, 10'h155}, FB, got);
    chk(got === {2'b00, held}, "R6", "frame content bad preamble", got, {2'b00, held});
    wait_sleep();
    held = mkdata(11);
    chk(cfg_now() === exp_cfg, "R9", "bad preamble keeps cfg", 32'(cfg_now()), 32'(exp_cfg));
    res_data = mkdata(12);
    do_frame({2'b10, 1'b0, 10'h2AA}, FB, got);
    wait_sleep();
    held = mkdata(12);
    chk(cfg_now() === exp_cfg, "R9", "enable low keeps cfg", 32'(cfg_now()), 32'(exp_cfg));

    // rising edges while chip select is high (R5)
    cs_n = 1'b1; tick(4);
    pulse_sck(3);
    chk(busy === 1'b0, "R5", "no wake with cs high", 32'(busy), 32'd0);
    cs_n = 1'b0; tick(4);
    chk(sdo === 1'b0, "R5", "still asleep flag", 32'(sdo), 32'd0);
    res_data = mkdata(13);
    do_frame({2'b10, 1'b0, 10'h0}, FB, got);
    chk(got === {2'b00, held}, "R5", "full frame after ignored edges", got, {2'b00, held});
    wait_sleep();
    held = mkdata(13);

    // mid-frame abort (R10)
    do_frame({2'b10, 1'b1, 10'h3FF}, 10, got);
    cs_n = 1'b1; tick(4);
    chk(sdo_oe === 1'b0, "R10", "oe after abort", 32'(sdo_oe), 32'd0);
    chk(busy === 1'b0, "R10", "no conversion after abort", 32'(busy), 32'd0);
    cs_n = 1'b0; tick(4);
    chk(sdo === 1'b0, "R10", "asleep flag after abort", 32'(sdo), 32'd0);
    res_data = mkdata(14);
    do_frame({2'b10, 1'b0, 10'h0}, FB, got);
    chk(got === {2'b00, held}, "R10", "held result after abort", got, {2'b00, held});
    chk(cfg_now() === exp_cfg, "R10", "cfg after abort", 32'(cfg_now()), 32'(exp_cfg));
    wait_sleep();
    held = mkdata(14);

    // stalled source and clock edges during conversion (R11 R4)
    res_valid = 1'b0;
    do_frame(mkcfg(3), FB, got);
    exp_cfg = mkcfg(3);
    tick(HALF);
    pulse_sck(4);
    chk(busy === 1'b1 && sdo === 1'b1, "R11", "edges in conversion ignored",
        32'({busy, sdo}), 32'd3);
    chk(res_ready === 1'b1, "R3", "ready after minimum length", 32'(res_ready), 32'd1);
    res_data = mkdata(15);
    tick(20);
    chk(busy === 1'b1, "R4", "stall holds conversion", 32'(busy), 32'd1);
    res_data = mkdata(16);
    res_valid = 1'b1;
    wait_sleep();
    chk(last_len > CC, "R4", "stretched conversion", 32'(last_len), 32'(CC + 1));
    held = mkdata(16);
    do_frame({2'b10, 1'b0, 10'h0}, FB, got);
    chk(got === {2'b00, held}, "R11", "accepted result read", got, {2'b00, held});
    chk(cfg_now() === exp_cfg, "R8", "cfg from stalled frame", 32'(cfg_now()), 32'(exp_cfg));
    wait_sleep();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule